// File: doc/BRIEF.md
# RTC serial command sequencer

This block lets a processor run short half-duplex serial exchanges with an external real-time clock device. Software sees two byte-wide registers: a command register, which reads back as a status byte, and a payload register. A valid command written to the command register lowers the chip-select. The block then shifts out a command byte, followed by a fixed number of payload bytes. Each command code fixes whether those payload bytes are sent or received, and how many there are.

Outbound payload works as follows. The first byte is taken from whatever the payload register holds when the command is issued. For every later byte the serial stream stops and raises a ready flag until the processor writes the next byte. Inbound payload works the other way round. Each received byte is placed in the payload register and raises the ready flag. Before every byte except the last, the stream stops until the processor reads that byte. The serial clock is derived from the system clock by a programmable divider. It runs only while a byte is being shifted, with one exception: an exchange cut off by an invalid command leaves the clock free-running until the next valid command.

Top module: `rtcSerialSeq`

## Requirements
- R1: A write to the command register (regSel=0) whose bit 4 is 1 and whose low nibble is 0x0 to 0xB, made while idle, starts a transaction. From the next cycle busy reads 1 and csN is 0.
- R2: The first byte shifted out is 0x60 OR the command nibble. Bits go LSB first. sdo changes only while sclk falls or is low, and sdi is sampled as sclk rises.
- R3: Payload length per nibble: 0x0 and 0x1 have none; 0x2/0x3 have 1; 0x4/0x5 have 7; 0x6/0x7 have 3; 0x8 to 0xB have 2. Even nibbles send and odd nibbles (from 0x3 up) receive. One command byte plus that many payload bytes cross the wire.
- R4: A command write with bit 4 clear, or with nibble 0xC to 0xF, starts nothing. Made while idle, it leaves csN at 1 and sclk at 0.
- R5: Such an invalid command made during a transaction ends it at once: busy clears and csN goes to 1. sclk then keeps toggling until the next valid command.
- R6: The status read (regSel=0) is bit 7 = ready, bits 6:5 = 0, bit 4 = busy, and bits 3:0 = the nibble of the last accepted command write.
- R7: Busy stays 1 throughout a transaction, including while it is stalled waiting for the processor.
- R8: A send transaction shifts the preloaded payload register as its first payload byte without stalling. Before each later byte it stalls with ready=1, and a payload write clears ready and resumes the stream.
- R9: A receive transaction stores each byte in the payload register and sets ready. Before each later byte it stalls until a payload read. The last byte ends the transaction with busy=0 and ready=1. With sdi held high, every byte reads 0xFF.
- R10: While idle, either a payload read or a payload write clears ready. During a send, a payload read leaves ready set.
- R11: After a transaction ends normally, sclk stays at 0 and csN at 1.
- R12: A valid command written while busy is ignored: the nibble in the status byte and the transaction in progress are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | 0 selects the command/status register, 1 the payload register |
| regWrEn | input | 1 | One-cycle register write strobe |
| regRdEn | input | 1 | One-cycle register read strobe (side effects only) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register, combinational |
| sclk | output | 1 | Gated serial clock, idle low |
| csN | output | 1 | Active-low chip-select, low for a whole transaction |
| sdo | output | 1 | Serial data to the device |
| sdi | input | 1 | Serial data from the device |

## Verification
The hardest state to reach is an invalid command arriving in the middle of a transfer. That is the only path that leaves the serial clock running without a chip-select, and normal use never gets there. The bench starts a seven-byte receive, waits part of a byte, and then writes an invalid code. It counts sclk edges with csN high, and then confirms that a following valid command parks the clock again. The stall points are reached by a serial device model that records every byte on the wire and supplies a computed response per byte index. A bus write of a valid command is injected during a send stall, and a read during a send stall, so the ignore rules are checked at the status byte and on the wire.

// File: rtl/rtcSeqPkg.sv
package rtcSeqPkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W = $clog2(BYTE_W);
  localparam int LEN_W = 3;
  localparam logic [3:0] CMD_PREFIX = 4'h6;
  localparam logic [3:0] LAST_VALID = 4'hB;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SHIFT,
    S_WAIT_TX,
    S_WAIT_RX
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic              loadCmd;
    logic              loadData;
    logic              loadCpu;
    logic              sample;
    logic              shift;
    logic              storeRx;
    logic [BYTE_W-1:0] cmdByte;
  } dpCtl_t;

  function automatic logic cmdValid(input logic [4:0] code);
    return code[4] && (code[3:0] <= LAST_VALID);
  endfunction

  function automatic logic [LEN_W-1:0] payloadLen(input logic [3:0] nib);
    case (nib)
      4'h2, 4'h3:             return 3'd1;
      4'h4, 4'h5:             return 3'd7;
      4'h6, 4'h7:             return 3'd3;
      4'h8, 4'h9, 4'hA, 4'hB: return 3'd2;
      default:                return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/rtcSeqCtrl.sv
module rtcSeqCtrl
  import rtcSeqPkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWr,
  input  logic       dataWr,
  input  logic       dataRd,
  input  logic [4:0] wrCode,
  output dpCtl_t     dpCtl,
  output logic       busy,
  output logic       ready,
  output logic [3:0] cmdNib,
  output logic       sclk,
  output logic       csN
);

  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  seqState_e        state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [LEN_W-1:0] bytesLeft;
  logic             isRx;
  logic             onCmd;
  logic             leak;
  logic             sclkQ;

  logic startValid, abortCmd, clockRun, tick, riseEdge, fallEdge, byteEnd;

  always_comb begin
    startValid = cmdWr && cmdValid(wrCode) && (state == S_IDLE);
    abortCmd   = cmdWr && !cmdValid(wrCode);
    clockRun   = (state == S_SHIFT) || leak;
    tick       = clockRun && (divCnt == DIV_LAST);
    riseEdge   = tick && !sclkQ;
    fallEdge   = tick && sclkQ;
    byteEnd    = (state == S_SHIFT) && fallEdge && (bitCnt == BIT_LAST);
  end

  always_comb begin
    dpCtl          = '0;
    dpCtl.loadCmd  = startValid;
    dpCtl.cmdByte  = {CMD_PREFIX, wrCode[3:0]};
    dpCtl.loadData = byteEnd && onCmd && !isRx && (bytesLeft != '0);
    dpCtl.loadCpu  = (state == S_WAIT_TX) && dataWr;
    dpCtl.sample   = (state == S_SHIFT) && riseEdge;
    dpCtl.shift    = (state == S_SHIFT) && fallEdge;
    dpCtl.storeRx  = byteEnd && isRx && !onCmd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      bytesLeft <= '0;
      isRx      <= 1'b0;
      onCmd     <= 1'b0;
      leak      <= 1'b0;
      sclkQ     <= 1'b0;
      ready     <= 1'b0;
      cmdNib    <= '0;
    end else if (startValid) begin
      state     <= S_SHIFT;
      cmdNib    <= wrCode[3:0];
      bytesLeft <= payloadLen(wrCode[3:0]);
      isRx      <= wrCode[0];
      onCmd     <= 1'b1;
      bitCnt    <= '0;
      divCnt    <= '0;
      sclkQ     <= 1'b0;
      leak      <= 1'b0;
      ready     <= 1'b0;
    end else if (abortCmd) begin
      cmdNib <= wrCode[3:0];
      state  <= S_IDLE;
      if (state != S_IDLE) leak <= 1'b1;
    end else begin
      if (clockRun) divCnt <= tick ? '0 : divCnt + DIV_W'(1);
      if (tick) sclkQ <= !sclkQ;
      if (dpCtl.shift) bitCnt <= bitCnt + BIT_W'(1);
      if (dataWr && (state == S_IDLE || state == S_WAIT_TX)) ready <= 1'b0;
      if (dataRd && (state == S_IDLE || state == S_WAIT_RX)) ready <= 1'b0;
      case (state)
        S_SHIFT: if (byteEnd) begin
          onCmd <= 1'b0;
          if (isRx && !onCmd) ready <= 1'b1;
          if (bytesLeft == '0) begin
            state <= S_IDLE;
          end else begin
            bytesLeft <= bytesLeft - LEN_W'(1);
            if (onCmd) begin
              state <= S_SHIFT;
            end else if (isRx) begin
              state <= S_WAIT_RX;
            end else begin
              state <= S_WAIT_TX;
              ready <= 1'b1;
            end
          end
        end
        S_WAIT_TX: if (dataWr) begin
          state  <= S_SHIFT;
          divCnt <= '0;
        end
        S_WAIT_RX: if (dataRd) begin
          state  <= S_SHIFT;
          divCnt <= '0;
        end
        default: ;
      endcase
    end
  end

  assign busy = (state != S_IDLE);
  assign csN  = (state == S_IDLE);
  assign sclk = sclkQ;

  // R11: clock parked low whenever idle and not left running by an abort
  a_r11_sclk_parked: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !leak) |-> !sclkQ);

  // R7: every stall point shows ready
  a_r7_stall_ready: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_TX || state == S_WAIT_RX) |-> ready);

  // R8: payload write during a send stall resumes and drops ready
  a_r8_write_resumes: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WAIT_TX && dataWr) |=> (!ready && state == S_SHIFT));

  // R12: valid command while busy leaves the nibble alone
  a_r12_busy_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && cmdWr && cmdValid(wrCode)) |=> $stable(cmdNib));

endmodule

// File: rtl/rtcSeqDatapath.sv
module rtcSeqDatapath
  import rtcSeqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            dpCtl,
  input  logic              cpuWr,
  input  logic [BYTE_W-1:0] cpuData,
  input  logic              sdi,
  output logic              sdo,
  output logic [BYTE_W-1:0] dataReg
);

  logic [BYTE_W-1:0] shiftReg;
  logic              sampleBit;
  logic [BYTE_W-1:0] rxByte;

  // LSB first: the bit captured last enters at the top
  assign rxByte = {sampleBit, shiftReg[BYTE_W-1:1]};
  assign sdo    = shiftReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      dataReg   <= '0;
    end else begin
      if (dpCtl.sample) sampleBit <= sdi;
      if (dpCtl.loadCmd)       shiftReg <= dpCtl.cmdByte;
      else if (dpCtl.loadData) shiftReg <= dataReg;
      else if (dpCtl.loadCpu)  shiftReg <= cpuData;
      else if (dpCtl.shift)    shiftReg <= rxByte;
      if (dpCtl.storeRx)  dataReg <= rxByte;
      else if (cpuWr)     dataReg <= cpuData;
    end
  end

  // R2: a freshly loaded command byte carries the fixed prefix
  a_r2_prefix: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.loadCmd |=> (shiftReg[BYTE_W-1:4] == CMD_PREFIX));

endmodule

// File: rtl/rtcSerialSeq.sv
module rtcSerialSeq
  import rtcSeqPkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regSel,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sclk,
  output logic       csN,
  output logic       sdo,
  input  logic       sdi
);

  dpCtl_t            dpCtl;
  logic              busy, ready;
  logic [3:0]        cmdNib;
  logic [BYTE_W-1:0] dataReg;
  logic              cmdWr, dataWr, dataRd;

  assign cmdWr  = regWrEn && !regSel;
  assign dataWr = regWrEn && regSel;
  assign dataRd = regRdEn && regSel;

  rtcSeqCtrl #(.HALF_DIV(HALF_DIV)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .cmdWr  (cmdWr),
    .dataWr (dataWr),
    .dataRd (dataRd),
    .wrCode (regWrData[4:0]),
    .dpCtl  (dpCtl),
    .busy   (busy),
    .ready  (ready),
    .cmdNib (cmdNib),
    .sclk   (sclk),
    .csN    (csN)
  );

  rtcSeqDatapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .dpCtl   (dpCtl),
    .cpuWr   (dataWr),
    .cpuData (regWrData),
    .sdi     (sdi),
    .sdo     (sdo),
    .dataReg (dataReg)
  );

  assign regRdData = regSel ? dataReg : {ready, 2'b00, busy, cmdNib};

  // R2: data out holds steady across the high phase of the clock
  a_r2_sdo_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk && $past(sclk)) |-> $stable(sdo));

endmodule

// File: tb/rtcSerialSeq_tb_top.sv
module rtcSerialSeq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regSel = 1'b0, regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sclk, csN, sdo, sdi;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 0;

  always #5 clk = !clk;

  rtcSerialSeq #(.HALF_DIV(2)) dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData),
    .sclk(sclk), .csN(csN), .sdo(sdo), .sdi(sdi)
  );

  // ---------------- serial device model ----------------
  logic       devPresent = 1'b1;
  int         devBit = 0;
  int         devByte = 0;
  int         capN = 0;
  logic [7:0] capShift = 8'h00;
  logic [7:0] capBytes [0:511];

  function automatic logic [7:0] respByte(input int k);
    return 8'((k * 91) ^ 195);
  endfunction

  logic [7:0] curResp;
  assign curResp = respByte(devByte);
  assign sdi = devPresent ? curResp[devBit[2:0]] : 1'b1;

  always @(posedge sclk or posedge csN) begin
    if (csN) begin
      devBit  = 0;
      devByte = 0;
    end else begin
      capShift[devBit[2:0]] = sdo;
      if (devBit == 7) begin
        capBytes[capN] = capShift;
        capN++;
        devBit = 0;
        devByte++;
      end else begin
        devBit++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic sel, output logic [7:0] d);
    @(negedge clk);
    regSel = sel; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // poll status until bit idx equals want; sawR notes any ready seen
  task automatic pollStatus(input int idx, input logic want,
                            output logic [7:0] s, output bit sawR);
    bit ok = 0;
    sawR = 0;
    for (int k = 0; k < 5000; k++) begin
      rdReg(1'b0, s);
      if (s[7]) sawR = 1;
      if (s[idx] == want) begin ok = 1; break; end
    end
    if (!ok) chk("R7", 32'(s), 32'hFFFF, "poll timeout");
  endtask

  task automatic countToggles(input int cycles, output int toggles);
    logic prev = sclk;
    toggles = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (sclk !== prev) toggles++;
      prev = sclk;
    end
  endtask

  task automatic runSend(input logic [3:0] nib, input int n,
                         input bit probeRead, input bit probeCmd);
    logic [7:0] s, d;
    logic [7:0] p [0:7];
    int base;
    bit sawR;
    for (int i = 0; i < 8; i++) p[i] = 8'(nib * 16 + i * 7 + 1);
    base = capN;
    wrReg(1'b1, p[0]);
    wrReg(1'b0, {4'h1, nib});
    rdReg(1'b0, s);
    chk("R1", {s[4], csN}, 2'b10, "busy/csN after start");
    chk("R6", {s[6:5], s[3:0]}, {2'b00, nib}, "status fields");
    for (int i = 1; i < n; i++) begin
      pollStatus(7, 1'b1, s, sawR);
      chk("R7", s[4], 1'b1, "busy during send stall");
      if (probeRead && i == 1) begin
        rdReg(1'b1, d);
        rdReg(1'b0, s);
        chk("R10", s[7], 1'b1, "read during send keeps ready");
      end
      if (probeCmd && i == 1) begin
        wrReg(1'b0, 8'h11);
        rdReg(1'b0, s);
        chk("R12", {s[4], s[3:0]}, {1'b1, nib}, "valid cmd while busy");
      end
      wrReg(1'b1, p[i]);
      rdReg(1'b0, s);
      chk("R8", s[7], 1'b0, "write clears ready");
    end
    pollStatus(4, 1'b0, s, sawR);
    if (n <= 1) chk("R8", 32'(sawR), 0, "no stall for first byte");
    chk("R3", capN - base, n + 1, "bytes on wire");
    chk("R2", capBytes[base], {4'h6, nib}, "command byte");
    for (int i = 0; i < n; i++)
      chk("R8", capBytes[base + 1 + i], p[i], "sent payload");
    chk("R11", {csN, sclk}, 2'b10, "parked after send");
  endtask

  task automatic runRecv(input logic [3:0] nib, input int n, input bit present);
    logic [7:0] s, d, e;
    int base;
    bit sawR;
    devPresent = present;
    base = capN;
    wrReg(1'b0, {4'h1, nib});
    for (int i = 0; i < n; i++) begin
      pollStatus(7, 1'b1, s, sawR);
      if (i == n - 1) chk("R9", s[4], 1'b0, "busy clear at last byte");
      else            chk("R7", s[4], 1'b1, "busy during receive stall");
      rdReg(1'b1, d);
      e = present ? respByte(i + 1) : 8'hFF;
      chk("R9", d, e, "received byte");
      rdReg(1'b0, s);
      chk("R10", s[7], 1'b0, "read clears ready");
    end
    chk("R3", capN - base, n + 1, "bytes on wire");
    chk("R2", capBytes[base], {4'h6, nib}, "command byte");
    chk("R11", {csN, sclk}, 2'b10, "parked after receive");
    devPresent = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [7:0] s;
    int tg;
    bit sawR;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    rdReg(1'b0, s);
    chk("R6", s, 8'h00, "reset status");
    chk("R11", {csN, sclk}, 2'b10, "reset pins");

    // sends and zero-length commands: even nibbles plus 0x1
    runSend(4'h0, 0, 0, 0);
    runSend(4'h1, 0, 0, 0);
    runSend(4'h2, 1, 0, 0);
    runSend(4'h4, 7, 1, 0);
    runSend(4'h6, 3, 0, 0);
    runSend(4'h8, 2, 0, 1);
    runSend(4'hA, 2, 0, 0);
    runSend(4'h4, 7, 0, 1);

    // receives with device present and absent
    for (int pass = 0; pass < 2; pass++) begin
      runRecv(4'h3, 1, pass == 0);
      runRecv(4'h5, 7, pass == 0);
      runRecv(4'h7, 3, pass == 0);
      runRecv(4'h9, 2, pass == 0);
      runRecv(4'hB, 2, pass == 0);
    end

    // R10: write while idle clears a pending ready
    wrReg(1'b0, 8'h13);
    pollStatus(4, 1'b0, s, sawR);
    chk("R9", s[7], 1'b1, "ready after last rx byte");
    wrReg(1'b1, 8'h00);
    rdReg(1'b0, s);
    chk("R10", s[7], 1'b0, "idle write clears ready");

    // R4: every invalid code while idle
    for (int c = 0; c < 32; c++) begin
      if (c[4] && c[3:0] <= 4'hB) continue;
      wrReg(1'b0, 8'(c));
      rdReg(1'b0, s);
      chk("R4", {s[4], s[3:0]}, {1'b0, 4'(c)}, "invalid code status");
      countToggles(12, tg);
      chk("R4", {tg, csN}, {32'd0, 1'b1}, "invalid code pins quiet");
    end

    // R5: invalid command mid-transfer leaves the clock running
    wrReg(1'b0, 8'h15);
    repeat (10) @(negedge clk);
    wrReg(1'b0, 8'h07);
    rdReg(1'b0, s);
    chk("R5", {s[4], csN}, 2'b01, "abort drops busy and cs");
    countToggles(20, tg);
    chk("R5", 32'(tg > 0), 1, "clock keeps running after abort");
    chk("R5", csN, 1'b1, "cs stays high while clock leaks");
    runSend(4'h0, 0, 0, 0);
    countToggles(20, tg);
    chk("R11", tg, 0, "clock gated after next valid command");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule